// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Unit

This block is the sending half of an I2C bus master that shares the bus with other masters. The host loads a byte and asks for a start. The block then creates a START condition and drives SCL with its own divider. It shifts the byte out on the open-drain SDA line, most significant bit first, and gives a ninth acknowledge clock in which SDA is released. If the host has loaded a further byte by that point, the block sends it at once. If not, it ends with a STOP condition.

On every data bit the block reads the bus back at the rising edge of SCL. When the block has released SDA but the wired-AND line is low, another master has won the bus. The block then takes three actions in the same clock edge: it lets go of SDA, it stops clocking SCL, and it drops out of master and transmit mode so that it acts as a slave receiver. A sticky arbitration-lost flag records the event. Only three host accesses clear it: a data write, a data read or a control write. While the flag is set, start requests have no effect.

The host side uses plain register strobes, not a stream. The data holding register keeps one entry. A write always lands in it, and a second write before the byte is taken replaces the first. There is no back-pressure. The register is emptied when the block loads a byte into its shifter.

Top module: `i2c_arb_tx`

## Requirements
- R1: After reset, neither SCL nor SDA is pulled low (`scl_oe` = 0, `sda_oe` = 0), and `mst_o`, `trx_o` and `al_o` are all 0.
- R2: An accepted start request sets `mst_o` and `trx_o` on the next clock edge. The bus then shows a START condition (SDA falls while SCL is high), nine SCL pulses per byte with the data bits MSB first and the ninth slot released, and a STOP condition (SDA rises while SCL is high). The total is 9 per byte plus 1 pulse for the stop. Each SCL low phase lasts at least `clk_div` clocks, for `clk_div` >= 4. After the stop, `mst_o` and `trx_o` return to 0.
- R3: During a transfer, SDA changes only while SCL is held low, except at the single START and the single STOP.
- R4: A byte written while a transfer is running is sent straight after the acknowledge slot, with no new START. If two writes arrive before the load, only the latest byte is sent.
- R5: At the SCL rising edge of a data bit, if the block has released SDA and the line reads low, `al_o` becomes 1 on the third clock edge after the SCL line goes high. On that same edge both `sda_oe` and `scl_oe` go to 0.
- R6: After arbitration is lost, the block produces no further SCL pulses. `mst_o` and `trx_o` clear on the same edge that sets `al_o`.
- R7: While the line matches the driven bits, no arbitration loss is flagged. Checking carries on into the following byte, so a competitor that sent the same first byte can still lose or win in the second byte.
- R8: `al_o` stays set until a clock edge sees `dat_we`, `dat_re` or `ctl_we`. If a clear and a new loss fall on the same edge, the flag ends set.
- R9: A start request is ignored while `mst_o` or `al_o` is 1.
- R10: The acknowledge slot is never compared, so a receiver pulling SDA low there does not set `al_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Length of each SCL low phase and high phase, in clocks (>= 4) |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| dat_we | input | 1 | Data register write strobe; also clears the arbitration flag |
| dat_wdata | input | 8 | Byte to send |
| dat_re | input | 1 | Data register read strobe; clears the arbitration flag |
| dat_rdata | output | 8 | Current contents of the data register |
| ctl_we | input | 1 | Control register write strobe; clears the arbitration flag |
| start_req | input | 1 | Request to start a transfer |
| mst_o | output | 1 | Master mode active |
| trx_o | output | 1 | Transmit mode active |
| al_o | output | 1 | Sticky arbitration-lost flag |

## Verification
Setting the arbitration flag on a loss and clearing it from the host can land on the same clock edge. The bench provokes this with a rival master that wins at a known bit. It watches the SCL line go high at that bit and pulses `ctl_we` once at each of four successive edges, in four separate runs. The expected result is that the flag survives every pulse up to and including the colliding edge, and is cleared by the pulse one edge later.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] ACK_SLOT = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STA_A,
    ST_STA_B,
    ST_LOW,
    ST_HIGH,
    ST_STO_A,
    ST_STO_B,
    ST_STO_C
  } bus_st_t;
endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= raw_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_arb_bitctl.sv
module i2c_arb_bitctl
  import i2c_arb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     clk_div,
  input  logic              go_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              more_i,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  output logic              ld_o,
  output logic              lost_o,
  output logic              done_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  bus_st_t           st;
  logic [DW-1:0]     cnt;
  logic [DW:0]       cnt_nx;
  logic              hit;
  logic [3:0]        bitn;
  logic [BYTE_W-1:0] sh;
  logic              sda_q;
  logic              hi_seen;
  logic              scl_prev;
  logic              scl_rise;
  logic              ack_slot;

  assign cnt_nx   = {1'b0, cnt} + 1'b1;
  assign hit      = cnt_nx >= {1'b0, clk_div};
  assign scl_rise = scl_lvl_i & ~scl_prev;
  assign ack_slot = (bitn == ACK_SLOT);

  assign lost_o   = (st == ST_HIGH) && !hi_seen && scl_rise && !ack_slot
                    && sda_q && !sda_lvl_i;
  assign ld_o     = ((st == ST_IDLE) && go_i)
                 || ((st == ST_HIGH) && hi_seen && hit && ack_slot && more_i);
  assign done_o   = (st == ST_STO_C) && hit;
  assign scl_oe_o = (st == ST_STA_B) || (st == ST_LOW) || (st == ST_STO_A);
  assign sda_oe_o = !sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_prev <= 1'b1;
    else        scl_prev <= scl_lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      sda_q   <= 1'b1;
      hi_seen <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          sda_q <= 1'b1;
          cnt   <= '0;
          if (go_i) begin
            st   <= ST_STA_A;
            sh   <= data_i;
            bitn <= '0;
          end
        end
        ST_STA_A: begin
          sda_q <= 1'b0;
          if (hit) begin cnt <= '0; st <= ST_STA_B; end
          else cnt <= cnt + 1'b1;
        end
        ST_STA_B: begin
          if (hit) begin cnt <= '0; st <= ST_LOW; end
          else cnt <= cnt + 1'b1;
        end
        ST_LOW: begin
          if (cnt == '0) sda_q <= ack_slot ? 1'b1 : sh[BYTE_W-1];
          if (hit) begin cnt <= '0; hi_seen <= 1'b0; st <= ST_HIGH; end
          else cnt <= cnt + 1'b1;
        end
        ST_HIGH: begin
          if (lost_o) begin
            st    <= ST_IDLE;
            sda_q <= 1'b1;
            cnt   <= '0;
          end else if (!hi_seen) begin
            if (scl_rise) hi_seen <= 1'b1;
          end else if (hit) begin
            cnt <= '0;
            if (ack_slot) begin
              if (more_i) begin
                sh   <= data_i;
                bitn <= '0;
                st   <= ST_LOW;
              end else begin
                st <= ST_STO_A;
              end
            end else begin
              sh   <= {sh[BYTE_W-2:0], 1'b0};
              bitn <= bitn + 1'b1;
              st   <= ST_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STO_A: begin
          if (cnt == '0) sda_q <= 1'b0;
          if (hit) begin cnt <= '0; hi_seen <= 1'b0; st <= ST_STO_B; end
          else cnt <= cnt + 1'b1;
        end
        ST_STO_B: begin
          if (!hi_seen) begin
            if (scl_rise) hi_seen <= 1'b1;
          end else if (hit) begin
            cnt <= '0;
            st  <= ST_STO_C;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STO_C: begin
          sda_q <= 1'b1;
          if (hit) begin cnt <= '0; st <= ST_IDLE; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |=> (!sda_oe_o && !scl_oe_o));

  // R3
  sda_hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HIGH && !lost_o) |=> $stable(sda_oe_o));
endmodule

// File: rtl/i2c_arb_regs.sv
module i2c_arb_regs
  import i2c_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_we,
  input  logic [BYTE_W-1:0] dat_wdata,
  input  logic              dat_re,
  input  logic              ctl_we,
  input  logic              start_req,
  input  logic              ld_i,
  input  logic              lost_i,
  input  logic              done_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              full_o,
  output logic              go_o,
  output logic              mst_o,
  output logic              trx_o,
  output logic              al_o
);
  logic              al_q, mst_q, trx_q, full_q;
  logic [BYTE_W-1:0] data_q;
  logic              clr;

  assign clr  = dat_we | dat_re | ctl_we;
  assign go_o = start_req & ~mst_q & ~al_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q   <= 1'b0;
      mst_q  <= 1'b0;
      trx_q  <= 1'b0;
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (lost_i)   al_q <= 1'b1;
      else if (clr) al_q <= 1'b0;

      if (lost_i || done_i) begin
        mst_q <= 1'b0;
        trx_q <= 1'b0;
      end else if (go_o) begin
        mst_q <= 1'b1;
        trx_q <= 1'b1;
      end

      if (dat_we)    full_q <= 1'b1;
      else if (ld_i) full_q <= 1'b0;

      if (dat_we) data_q <= dat_wdata;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign mst_o  = mst_q;
  assign trx_o  = trx_q;
  assign al_o   = al_q;

  // R6
  lost_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_i |=> (al_o && !mst_o && !trx_o));

  // R8
  al_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (al_o && !clr) |=> al_o);

  // R8
  al_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !lost_i) |=> !al_o);

  // R9
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && al_o && !mst_o) |=> !mst_o);
endmodule

// File: rtl/i2c_arb_tx.sv
module i2c_arb_tx
  import i2c_arb_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             dat_we,
  input  logic [7:0]       dat_wdata,
  input  logic             dat_re,
  output logic [7:0]       dat_rdata,
  input  logic             ctl_we,
  input  logic             start_req,
  output logic             mst_o,
  output logic             trx_o,
  output logic             al_o
);
  logic [1:0]        lvl;
  logic              ld, lost, done, go, full;
  logic [BYTE_W-1:0] data;

  i2c_arb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i ({sda_i, scl_i}),
    .lvl_o (lvl)
  );

  i2c_arb_bitctl #(.DW(DIV_W)) u_bitctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_div   (clk_div),
    .go_i      (go),
    .data_i    (data),
    .more_i    (full),
    .scl_lvl_i (lvl[0]),
    .sda_lvl_i (lvl[1]),
    .ld_o      (ld),
    .lost_o    (lost),
    .done_o    (done),
    .scl_oe_o  (scl_oe),
    .sda_oe_o  (sda_oe)
  );

  i2c_arb_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .dat_we    (dat_we),
    .dat_wdata (dat_wdata),
    .dat_re    (dat_re),
    .ctl_we    (ctl_we),
    .start_req (start_req),
    .ld_i      (ld),
    .lost_i    (lost),
    .done_i    (done),
    .data_o    (data),
    .full_o    (full),
    .go_o      (go),
    .mst_o     (mst_o),
    .trx_o     (trx_o),
    .al_o      (al_o)
  );

  assign dat_rdata = data;
endmodule

// File: tb/test_i2c_arb_tx.sv
module test_i2c_arb_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] div = 8'd4;
  logic dat_we = 0, dat_re = 0, ctl_we = 0, start_req = 0;
  logic [7:0] wdata = 0;
  logic scl_oe, sda_oe, mst, trx, al;
  logic [7:0] rdata;
  logic pull = 1'b0;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | pull);

  i2c_arb_tx i_i2c_arb_tx (
    .clk(clk), .rst_n(rst_n), .clk_div(div),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .dat_we(dat_we), .dat_wdata(wdata), .dat_re(dat_re), .dat_rdata(rdata),
    .ctl_we(ctl_we), .start_req(start_req),
    .mst_o(mst), .trx_o(trx), .al_o(al)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // rival master / bus monitor
  logic rival [0:35];
  int   rival_n = 0;
  bit   mon_clr = 0;
  int   rises = 0, idx = 0, starts = 0, stops = 0, cur_low = 0, min_low = 1000;
  logic rec [0:63];
  logic scl_p = 1'b1, sda_p = 1'b1;

  always @(negedge clk) begin
    if (mon_clr) begin
      rises = 0; idx = 0; starts = 0; stops = 0; pull = 1'b0;
      cur_low = 0; min_low = 1000;
    end else begin
      if (scl_line && scl_p && sda_p && !sda_line) starts++;
      if (scl_line && scl_p && !sda_p && sda_line) stops++;
      if (!scl_line) cur_low++;
      if (scl_p && !scl_line) begin
        pull = (idx < rival_n) ? !rival[idx] : 1'b0;
        idx++;
      end
      if (!scl_p && scl_line) begin
        if (rises < 64) rec[rises] = sda_line;
        rises++;
        if (cur_low < min_low) min_low = cur_low;
        cur_low = 0;
      end
    end
    scl_p = scl_line;
    sda_p = !(sda_oe || pull);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] d);
    dat_we = 1; wdata = d; tick(1); dat_we = 0;
  endtask

  task automatic clear_mon();
    mon_clr = 1; tick(1); mon_clr = 0;
  endtask

  task automatic load_rival(input logic [7:0] b0, input logic [7:0] b1, input int nb,
                            input bit lose, input int lb, input int lp);
    logic [7:0] by [2];
    by[0] = b0; by[1] = b1;
    rival_n = nb * 9;
    for (int i = 0; i < nb * 9; i++) begin
      if (i % 9 == 8) rival[i] = 1'b0;
      else            rival[i] = by[i/9][7 - (i % 9)];
      if (lose && i == lb * 9 + lp) rival[i] = 1'b0;
    end
  endtask

  function automatic int exp_pulses(input int nb, input bit lose, input int lb, input int lp);
    return lose ? (lb * 9 + lp + 1) : (nb * 9 + 1);
  endfunction

  task automatic run_xfer(input logic [7:0] b0, input logic [7:0] b1, input int nb,
                          input bit lose, input int lb, input int lp);
    int exp_r, errs;
    logic [7:0] by [2];
    by[0] = b0; by[1] = b1;
    clear_mon();
    load_rival(b0, b1, nb, lose, lb, lp);
    put_byte(b0);
    start_req = 1; tick(1); start_req = 0;
    chk(mst && trx, "R2 mode set on start", int'({mst, trx}), 3);
    if (nb == 2) begin tick(3); put_byte(~b1); put_byte(b1); end
    tick(2); start_req = 1; tick(1); start_req = 0;   // R9: ignored while master
    for (int t = 0; t < 4000 && mst; t++) tick(1);
    tick(40);
    exp_r = exp_pulses(nb, lose, lb, lp);
    chk(rises == exp_r, lose ? "R6 pulses stop after loss" : "R2 pulse count / R9 no restart",
        rises, exp_r);
    chk(min_low >= int'(div), "R2 low phase length", min_low, int'(div));
    if (lose) begin
      chk(al == 1'b1, "R5 flag set on loss", al, 1);
      chk(!mst && !trx, "R6 mode cleared", int'({mst, trx}), 0);
      chk(!scl_oe && !sda_oe, "R5 lines released", int'({scl_oe, sda_oe}), 0);
      if (lb == 1) chk(al == 1'b1, "R7 equal first byte, loss in second", al, 1);
    end else begin
      errs = 0;
      for (int b = 0; b < nb; b++)
        for (int k = 0; k < 8; k++)
          if (rec[b*9+k] !== by[b][7-k]) errs++;
      chk(errs == 0, nb == 2 ? "R4 continued byte stream" : "R2 bit stream", errs, 0);
      chk(starts == 1, "R3 single start, no SDA change at SCL high", starts, 1);
      chk(stops == 1, "R2 stop condition", stops, 1);
      chk(al == 1'b0, "R10 ack slot not compared / R7 no loss", al, 0);
      chk(!mst && !trx, "R2 mode cleared after stop", int'({mst, trx}), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    tick(3);
    chk(!scl_oe && !sda_oe, "R1 lines released in reset", int'({scl_oe, sda_oe}), 0);
    chk(!mst && !trx && !al, "R1 status clear in reset", int'({mst, trx, al}), 0);
    rst_n = 1'b1;
    tick(3);

    div = 8'd4;
    run_xfer(8'hA5, 8'h00, 1, 0, 0, 0);
    div = 8'd5;
    run_xfer(8'h3C, 8'hC3, 2, 0, 0, 0);

    // loss on the very first bit, then blocked start and read clear
    div = 8'd4;
    run_xfer(8'h80, 8'h00, 1, 1, 0, 0);
    clear_mon();
    start_req = 1; tick(1); start_req = 0;
    tick(30);
    chk(!mst && rises == 0, "R9 start ignored while flag set", rises, 0);
    chk(al == 1'b1, "R8 flag sticky", al, 1);
    dat_re = 1; tick(1); dat_re = 0;
    chk(al == 1'b0, "R8 cleared by data read", al, 0);

    // equal first byte, loss in the second one, cleared by control write
    run_xfer(8'h5A, 8'hFF, 2, 1, 1, 7);
    ctl_we = 1; tick(1); ctl_we = 0;
    chk(al == 1'b0, "R8 cleared by control write", al, 0);

    // collision between loss and a clear strobe
    div = 8'd6;
    for (int j = 0; j < 4; j++) begin
      clear_mon();
      load_rival(8'hFF, 8'h00, 1, 1, 0, 2);
      put_byte(8'hFF);
      start_req = 1; tick(1); start_req = 0;
      for (int t = 0; t < 2000 && rises < 2; t++) tick(1);
      for (int t = 0; t < 200 && scl_line; t++) tick(1);
      for (int t = 0; t < 200 && !scl_line; t++) tick(1);
      if (j == 3) begin
        tick(2);
        chk(al == 1'b0, "R5 flag not yet set two edges after SCL rise", al, 0);
        tick(1);
        chk(al == 1'b1, "R5 flag set on third edge", al, 1);
      end else begin
        tick(j);
      end
      ctl_we = 1; tick(1); ctl_we = 0;
      tick(10);
      chk(al == (j <= 2), j == 2 ? "R8 set wins over same-edge clear" : "R8 clear order",
          al, (j <= 2) ? 1 : 0);
      for (int t = 0; t < 100 && mst; t++) tick(1);
    end
    put_byte(8'h00);
    chk(al == 1'b0, "R8 cleared by data write", al, 0);

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [7:0] b0, b1;
      int nb, lb, lp;
      bit lose;
      div  = 8'(4 + $urandom % 4);
      b0   = 8'($urandom);
      b1   = 8'($urandom);
      lose = ($urandom % 2) == 1;
      nb   = 1 + int'($urandom % 2);
      lb   = 0; lp = 0;
      if (lose) begin
        lb = int'($urandom % 2);
        nb = lb + 1;
        lp = int'($urandom % 8);
        if (lb == 0) b0[7-lp] = 1'b1;
        else         b1[7-lp] = 1'b1;
      end
      run_xfer(b0, b1, nb, lose, lb, lp);
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule